// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

An eight-pin bidirectional general-purpose I/O port that sits on a simple register bus. Software sets a direction bit per pin, writes an output latch, and reads pin levels. Pin levels pass through a two-flop synchronizer first. The block drives a per-pin output-enable and output value toward the pads. It also drives one weak pull-up request per pin. All pull-ups share a single active-low disable bit, and the pull-up of any pin that drives an output is always off. An analog-select mask makes chosen pins read as 0 and removes them from change detection.

Change detection covers the upper pins only, from pin 7 down to pin 4. The block keeps a snapshot of the synchronized pins. The snapshot is refreshed on every read or write of the pin register. Any upper pin that is a digital input and differs from its snapshot sets a sticky change flag, and it keeps setting the flag on every cycle until a pin-register access brings the snapshot up to date. Software clears the flag by writing 0 to the flag bit. A clear can only take effect once the mismatch has gone, which is at the earliest one cycle after the access. A wake output is raised while the flag is set and change interrupts are enabled.

Each bus access is a one-cycle strobe on `bus_wr` or `bus_rd`. A read returns its data one cycle later, qualified by `bus_rvalid`. The read response has no ready signal: the port never stalls, and the host must take each response in the cycle it is offered.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset the direction register (address 0) reads 0xFF, the latch (address 1) reads 0x00, the control register (address 3) reads 0x01 and the analog mask (address 4) reads 0x0F. In the control register, bit 0 disables the pull-ups, bit 1 enables change interrupts and bit 2 is the change flag. After reset the flag is 0 and wake is 0.
- R2: In the cycle after a write to the direction register, `pad_oe` equals the inverse of the written value. `pad_out` always equals the latch, and a write to either address 1 or address 2 loads the latch.
- R3: A read of the latch address returns the latched value whatever the pin levels are.
- R4: `pull_en[i]` is 1 exactly when control bit 0 is 0 and pin i is an input (direction bit 1).
- R5: A read of address 2 returns the pin levels after two synchronizer flops. Pins whose analog-mask bit is 1 read as 0.
- R6: Only pins 7 to 4 take part in change detection, and only while they are inputs with their analog bit at 0. Changes on pins that drive outputs or are analog leave the flag at 0.
- R7: The flag sets when a participating pin differs from the snapshot taken at the last read or write of address 2.
- R8: While a mismatch persists, writing 0 to control bit 2 leaves the flag set. A set in the same cycle as a clear wins.
- R9: A clear written in the cycle after an access to address 2, with the pins stable, clears the flag, and the flag stays clear.
- R10: `wake` is 1 exactly when the flag is 1 and control bit 1 is 1.
- R11: Writing 1 to control bit 2 never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response valid, one cycle after bus_rd |
| pad_in | input | 8 | Asynchronous pin levels |
| pad_out | output | 8 | Output value toward the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pull_en | output | 8 | Per-pin weak pull-up request |
| irq_flag | output | 1 | Port change flag |
| wake | output | 1 | Wake request |

## Verification
The checker watches, on every cycle, the properties that link signals directly. Pull-up and output-enable are never both active on a pin. The flag rises only after a mismatch and stays set while the mismatch lasts. A clear without a mismatch takes effect, and software can never set the flag. Wake implies the flag, and the output enables follow direction writes. The bench scenarios cover the rest. They show the synchronizer latency, that analog pins read as 0, that outputs and analog pins are excluded from detection, and the sequence in which a clear fails while the snapshot is stale and succeeds after a port read or write.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR = 3'd0,
    RA_LAT = 3'd1,
    RA_PIN = 3'd2,
    RA_CTL = 3'd3,
    RA_ANA = 3'd4
  } reg_addr_e;

  localparam int CTL_PUDIS = 0;
  localparam int CTL_IE    = 1;
  localparam int CTL_FLAG  = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_sync <= '0;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_chg_pkg::*;
#(
  parameter int W      = 8,
  parameter int CHG_LO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pin_sync,
  input  logic              flag,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      lat,
  output logic [W-1:0]      ana,
  output logic              pudis,
  output logic              ie,
  output logic              port_acc,
  output logic              flag_clr,
  output logic [W-1:0]      rdata,
  output logic              rvalid
);
  localparam logic [W-1:0] ANA_RST = W'((1 << CHG_LO) - 1);

  reg_addr_e    ra;
  logic [W-1:0] rd_mux;

  assign ra       = reg_addr_e'(addr);
  assign port_acc = (wr || rd) && (ra == RA_PIN);
  assign flag_clr = wr && (ra == RA_CTL) && !wdata[CTL_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir   <= '1;
      lat   <= '0;
      ana   <= ANA_RST;
      pudis <= 1'b1;
      ie    <= 1'b0;
    end else if (wr) begin
      case (ra)
        RA_DIR:  dir <= wdata;
        RA_LAT,
        RA_PIN:  lat <= wdata;
        RA_CTL: begin
          pudis <= wdata[CTL_PUDIS];
          ie    <= wdata[CTL_IE];
        end
        RA_ANA:  ana <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (ra)
      RA_DIR: rd_mux = dir;
      RA_LAT: rd_mux = lat;
      RA_PIN: rd_mux = pin_sync & ~ana;
      RA_CTL: begin
        rd_mux[CTL_PUDIS] = pudis;
        rd_mux[CTL_IE]    = ie;
        rd_mux[CTL_FLAG]  = flag;
      end
      RA_ANA: rd_mux = ana;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int W      = 8,
  parameter int CHG_LO = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] ana,
  input  logic         port_acc,
  input  logic         flag_clr,
  output logic         mismatch,
  output logic         flag
);
  logic [W-1:0] snap;
  logic [W-1:0] part;

  for (genvar i = 0; i < W; i++) begin : g_part
    if (i >= CHG_LO) begin : g_watch
      assign part[i] = dir[i] & ~ana[i];
    end else begin : g_skip
      assign part[i] = 1'b0;
    end
  end

  assign mismatch = |((pin_sync ^ snap) & part);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap <= '0;
      flag <= 1'b0;
    end else begin
      if (port_acc) snap <= pin_sync;
      if (mismatch)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int W      = 8,
  parameter int CHG_LO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              bus_rvalid,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pull_en,
  output logic              irq_flag,
  output logic              wake
);
  logic [W-1:0] pin_sync, dir, lat, ana;
  logic         pudis, ie, port_acc, flag_clr, mismatch;

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pad_in), .q_sync(pin_sync)
  );

  gpio_regs #(.W(W), .CHG_LO(CHG_LO)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .pin_sync(pin_sync), .flag(irq_flag),
    .dir(dir), .lat(lat), .ana(ana), .pudis(pudis), .ie(ie),
    .port_acc(port_acc), .flag_clr(flag_clr),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  gpio_chg_detect #(.W(W), .CHG_LO(CHG_LO)) u_chg (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .dir(dir), .ana(ana),
    .port_acc(port_acc), .flag_clr(flag_clr),
    .mismatch(mismatch), .flag(irq_flag)
  );

  for (genvar i = 0; i < W; i++) begin : g_pad
    assign pad_oe[i]  = ~dir[i];
    assign pull_en[i] = ~pudis & dir[i];
  end

  assign pad_out = lat;
  assign wake    = irq_flag & ie;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk
  import gpio_chg_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pull_en,
  input logic              irq_flag,
  input logic              wake,
  input logic              mismatch,
  input logic              flag_clr
);
  a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_DIR) |=> (pad_oe == ~$past(bus_wdata)));

  a_r4_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en & pad_oe) == '0);

  a_r7_rise_needs_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(mismatch));

  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> irq_flag);

  a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !mismatch) |=> !irq_flag);

  a_r10_wake_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> irq_flag);

  a_r11_sw_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!mismatch && !irq_flag) |=> !irq_flag);
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .pad_oe(pad_oe), .pull_en(pull_en),
  .irq_flag(irq_flag), .wake(wake), .mismatch(mismatch), .flag_clr(flag_clr)
);

// File: tb/gpio_chg_port_test.sv
module gpio_chg_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, pad_in = '0;
  logic [7:0] bus_rdata, pad_out, pad_oe, pull_en;
  logic       bus_rvalid, irq_flag, wake;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  gpio_chg_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pull_en(pull_en), .irq_flag(irq_flag), .wake(wake)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb.push_back(e);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: compare each read response with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected response actual %h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(bus_rdata, e.val, e.tag);
      end
    end
  end

  initial begin
    #80000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(pad_oe, 8'h00, "R1 pad_oe");
    chk(pad_out, 8'h00, "R1 pad_out");
    chk(pull_en, 8'h00, "R1 pull_en");
    chk({7'd0, irq_flag}, 8'h00, "R1 flag");
    chk({7'd0, wake}, 8'h00, "R1 wake");
    rd(3'd0, 8'hFF, "R1 dir");
    rd(3'd1, 8'h00, "R1 lat");
    rd(3'd3, 8'h01, "R1 ctl");
    rd(3'd4, 8'h0F, "R1 ana");

    // R2 / R3 / R4
    wr(3'd1, 8'h3C);
    wr(3'd0, 8'hF0);
    chk(pad_oe, 8'h0F, "R2 oe after dir write");
    chk(pad_out, 8'h3C, "R2 pad_out");
    rd(3'd1, 8'h3C, "R3 latch not pins");
    wr(3'd3, 8'h00);
    chk(pull_en, 8'hF0, "R4 pull on inputs only");
    wr(3'd4, 8'h00);

    // R5 synchronizer latency
    pad_in = 8'h03;
    rd(3'd2, 8'h00, "R5 not yet synced");
    idle(2);
    rd(3'd2, 8'h03, "R5 synced");

    // R7 mismatch sets flag; R10 wake
    pad_in = 8'h13;
    idle(4);
    chk({7'd0, irq_flag}, 8'h01, "R7 flag set");
    chk({7'd0, wake}, 8'h00, "R10 wake off with ie 0");
    wr(3'd3, 8'h06);
    chk({7'd0, wake}, 8'h01, "R10 wake on");

    // R8 clear without access has no effect
    wr(3'd3, 8'h02);
    chk({7'd0, irq_flag}, 8'h01, "R8 clear lost");
    idle(1);
    chk({7'd0, irq_flag}, 8'h01, "R8 still set");

    // R9 read then clear
    rd(3'd2, 8'h13, "R9 pin read");
    wr(3'd3, 8'h02);
    chk({7'd0, irq_flag}, 8'h00, "R9 cleared after read");
    idle(3);
    chk({7'd0, irq_flag}, 8'h00, "R9 stays clear");
    chk({7'd0, wake}, 8'h00, "R10 wake follows flag");

    // R9 write access to pin register also refreshes snapshot
    pad_in = 8'h33;
    idle(4);
    chk({7'd0, irq_flag}, 8'h01, "R7 flag set bit5");
    wr(3'd2, 8'h5A);
    wr(3'd3, 8'h02);
    chk({7'd0, irq_flag}, 8'h00, "R9 cleared after write");
    chk(pad_out, 8'h5A, "R2 pin write loads latch");
    rd(3'd1, 8'h5A, "R3 latch readback");

    // R6 outputs excluded
    wr(3'd0, 8'h00);
    chk(pad_oe, 8'hFF, "R2 all outputs");
    chk(pull_en, 8'h00, "R4 no pull on outputs");
    pad_in = 8'hC3;
    idle(4);
    chk({7'd0, irq_flag}, 8'h00, "R6 outputs excluded");
    // R6 analog excluded, R5 analog reads 0
    wr(3'd4, 8'hF0);
    wr(3'd0, 8'hF0);
    idle(4);
    chk({7'd0, irq_flag}, 8'h00, "R6 analog excluded");
    rd(3'd2, 8'h03, "R5 analog reads 0");

    // R11 software write of 1 does not set
    wr(3'd3, 8'h06);
    idle(2);
    chk({7'd0, irq_flag}, 8'h00, "R11 no software set");
    rd(3'd3, 8'h02, "R11 ctl readback");

    idle(3);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL missing responses actual %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule